// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. Reads and writes complete in one cycle. Software selects how fast the timer counts, starts the countdown and then writes the counter register periodically to keep the system alive. The input clock passes through an 8-bit programmable prescaler and then a fixed post-divider of 16, 32, 64 or 128. Each resulting tick decrements a 16-bit down-counter. When the counter is already at zero and a tick arrives, the block reloads the counter from a reload register. Depending on the enable bits, it then raises a level interrupt, emits a one-clock system reset pulse, or does both.

A small state machine in the counting core sequences this behaviour. The states and transitions are:

- `ST_STOP`: counting is off. It moves to `ST_RUN` once the run bit is set.
- `ST_RUN`: counting is on. It returns to `ST_STOP` when the run bit is cleared. On an expiry it goes to `ST_FIRE_RST` if reset is enabled, and to `ST_FIRE_SOFT` if reset is not enabled.
- `ST_FIRE_RST` and `ST_FIRE_SOFT`: each lasts one cycle. Each then goes back to `ST_RUN`, or to `ST_STOP` if the run bit has been cleared in the meantime.

The system reset output is high exactly while the machine is in `ST_FIRE_RST`.

Top module: `wdog_periph`

## Requirements
- R1: After reset, control reads 0x8019 (run off, reset on, interrupt off, divide code 3, prescaler 0x80). Reload and counter both read 0x8000. `irq` and `sys_rst` are low.
- R2: Byte offsets are: control 0x0, reload 0x4, counter 0x8, interrupt clear 0xC. Control bits are: bit 0 reset enable, bit 2 interrupt enable, bits 4:3 divide code, bit 5 run, bits 15:8 prescaler P. All other control bits read 0. Reload and counter keep bits 15:0 of a write. The clear register reads 0.
- R3: While running, the counter decrements once every (P+1)*(16<<code) clocks. The first decrement takes effect that many clock edges after the edge that captured the write setting the run bit.
- R4: An expiry is a tick that finds the counter at 0. On an expiry the counter loads the reload value.
- R5: An expiry with interrupt enable set drives `irq` high, and `irq` stays high until it is cleared. With interrupt enable clear, `irq` does not rise.
- R6: An expiry with reset enable set gives a `sys_rst` pulse exactly one clock long, in the cycle after the expiry edge. With reset enable clear, no pulse is produced.
- R7: A write to the counter loads its value at once, even while running, and it overrides a tick in the same cycle.
- R8: Writing the clear register with bit 0 set lowers `irq`. Writing it with bit 0 clear has no effect. If a clear and an expiry land in the same cycle, the clear wins.
- R9: With the run bit clear, the counter holds its value except when it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid while `bus_sel` is high and `bus_wr` is low |
| irq | output | 1 | Level interrupt, pending expiry |
| sys_rst | output | 1 | One-clock system reset pulse |

## Verification
The hardest case to reach from the ports is an interrupt-clear write that lands on the same clock edge as an expiry. Only in that case does the R8 priority matter.

The stimulus sets P=0 and divide code 0, which makes the tick period exactly 16 clocks. It loads the counter with 0 and then sets the run bit. Because the expiry edge is then known to the cycle, the clear write is issued so that it is captured on exactly that edge. Randomised prescaler, divider and start values exercise the tick chain timing, with the counter read back at random offsets.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 16;
    localparam int PRE_W      = 8;
    localparam int DIV_W      = 2;
    localparam int BASE_SHIFT = 4;   // smallest post-divide is 2**4
    localparam int NUM_DIV    = 1 << DIV_W;

    // register byte offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 4'hC;

    // control field positions
    localparam int B_RST    = 0;
    localparam int B_IRQ    = 2;
    localparam int B_DIV_LO = 3;
    localparam int B_RUN    = 5;
    localparam int B_PRE_LO = 8;

    // reset values
    localparam logic [PRE_W-1:0] RV_PRESC = 8'h80;
    localparam logic [DIV_W-1:0] RV_DIV   = 2'b11;
    localparam logic [CNT_W-1:0] RV_CNT   = 16'h8000;

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic [DIV_W-1:0] div;
        logic             run;
        logic             irq_en;
        logic             rst_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_STOP      = 2'd0,
        ST_RUN       = 2'd1,
        ST_FIRE_RST  = 2'd2,
        ST_FIRE_SOFT = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_wval,
    output logic              irq_clr
);
    logic wr_ctrl, wr_reload;
    logic unused_wbits;

    assign wr_ctrl   = sel && wr && (addr == OFS_CTRL);
    assign wr_reload = sel && wr && (addr == OFS_RELOAD);
    assign cnt_load  = sel && wr && (addr == OFS_COUNT);
    assign irq_clr   = sel && wr && (addr == OFS_CLEAR) && wdata[0];
    assign cnt_wval  = wdata[CNT_W-1:0];

    assign unused_wbits = ^{wdata[DATA_W-1:B_PRE_LO+PRE_W], wdata[B_PRE_LO-1:B_RUN+1],
                            wdata[B_IRQ-1:B_RST+1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl.presc  <= RV_PRESC;
            ctrl.div    <= RV_DIV;
            ctrl.run    <= 1'b0;
            ctrl.irq_en <= 1'b0;
            ctrl.rst_en <= 1'b1;
        end else if (wr_ctrl) begin
            ctrl.presc  <= wdata[B_PRE_LO +: PRE_W];
            ctrl.div    <= wdata[B_DIV_LO +: DIV_W];
            ctrl.run    <= wdata[B_RUN];
            ctrl.irq_en <= wdata[B_IRQ];
            ctrl.rst_en <= wdata[B_RST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         reload <= RV_CNT;
        else if (wr_reload) reload <= wdata[CNT_W-1:0];
    end

    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            if (addr == OFS_CTRL) begin
                rdata[B_PRE_LO +: PRE_W] = ctrl.presc;
                rdata[B_DIV_LO +: DIV_W] = ctrl.div;
                rdata[B_RUN]             = ctrl.run;
                rdata[B_IRQ]             = ctrl.irq_en;
                rdata[B_RST]             = ctrl.rst_en;
            end else if (addr == OFS_RELOAD) begin
                rdata[CNT_W-1:0] = reload;
            end else if (addr == OFS_COUNT) begin
                rdata[CNT_W-1:0] = cnt;
            end
        end
    end
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] presc,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int POST_W = BASE_SHIFT + NUM_DIV - 1;

    logic [PRE_W-1:0]  pre_cnt;
    logic [POST_W-1:0] post_cnt;
    logic [POST_W-1:0] lim_tab [NUM_DIV];
    logic [POST_W-1:0] post_lim;
    logic              pre_hit;

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_lim
        assign lim_tab[g] = POST_W'((1 << (BASE_SHIFT + g)) - 1);
    end

    assign post_lim = lim_tab[div];
    assign pre_hit  = run && (pre_cnt >= presc);
    assign tick     = pre_hit && (post_cnt >= post_lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            post_cnt <= '0;
        end else if (!run) begin
            pre_cnt  <= '0;
            post_cnt <= '0;
        end else if (pre_hit) begin
            pre_cnt  <= '0;
            post_cnt <= tick ? '0 : post_cnt + 1'b1;
        end else begin
            pre_cnt  <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             irq_en,
    input  logic             rst_en,
    input  logic             tick,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_wval,
    input  logic [CNT_W-1:0] reload,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             irq,
    output logic             sys_rst
);
    wd_state_e state, nxt;
    logic      expire;

    assign expire = (state == ST_RUN) && tick && (cnt == '0) && !cnt_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STOP;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_STOP:      nxt = run ? ST_RUN : ST_STOP;
            ST_RUN: begin
                if (!run)        nxt = ST_STOP;
                else if (expire) nxt = rst_en ? ST_FIRE_RST : ST_FIRE_SOFT;
                else             nxt = ST_RUN;
            end
            ST_FIRE_RST,
            ST_FIRE_SOFT: nxt = run ? ST_RUN : ST_STOP;
            default:      nxt = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt <= RV_CNT;
        else if (cnt_load)                   cnt <= cnt_wval;
        else if (expire)                     cnt <= reload;
        else if (state == ST_RUN && tick)    cnt <= cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                irq <= 1'b0;
        else if (irq_clr)          irq <= 1'b0;
        else if (expire && irq_en) irq <= 1'b1;
    end

    always_comb begin
        sys_rst = (state == ST_FIRE_RST);
    end
endmodule

// File: rtl/wdog_periph.sv
module wdog_periph
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sys_rst
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_wval;
    logic             cnt_load;
    logic             irq_clr;
    logic             tick;
    logic             ctrl_run;
    logic             ctrl_irq_en;

    assign ctrl_run    = ctrl_q.run;
    assign ctrl_irq_en = ctrl_q.irq_en;

    wdog_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (bus_sel),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cnt      (cnt_q),
        .rdata    (bus_rdata),
        .ctrl     (ctrl_q),
        .reload   (reload_q),
        .cnt_load (cnt_load),
        .cnt_wval (cnt_wval),
        .irq_clr  (irq_clr)
    );

    wdog_tick u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_run),
        .presc (ctrl_q.presc),
        .div   (ctrl_q.div),
        .tick  (tick)
    );

    wdog_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_run),
        .irq_en   (ctrl_irq_en),
        .rst_en   (ctrl_q.rst_en),
        .tick     (tick),
        .cnt_load (cnt_load),
        .cnt_wval (cnt_wval),
        .reload   (reload_q),
        .irq_clr  (irq_clr),
        .cnt      (cnt_q),
        .irq      (irq),
        .sys_rst  (sys_rst)
    );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import wdog_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic              sys_rst,
    input logic [CNT_W-1:0]  cnt,
    input logic              run,
    input logic              irq_en
);
    logic clr_wr, cnt_wr;
    assign clr_wr = sel && wr && (addr == OFS_CLEAR) && wdata[0];
    assign cnt_wr = sel && wr && (addr == OFS_COUNT);

    // R6
    rst_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> !sys_rst);

    // R5
    irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);

    // R5
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !irq_en) |=> !irq);

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !irq);

    // R7
    load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wdata[CNT_W-1:0])));

    // R9
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));
endmodule

bind wdog_periph wdog_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (bus_sel),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .irq     (irq),
    .sys_rst (sys_rst),
    .cnt     (cnt_q),
    .run     (ctrl_run),
    .irq_en  (ctrl_irq_en)
);

// File: tb/test_wdog_periph.sv
module test_wdog_periph;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        sys_rst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int pulses = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_periph i_wdog_periph (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .sys_rst   (sys_rst)
    );

    always @(negedge clk) if (sys_rst) pulses++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int period(input int p, input int code);
        return (p + 1) * (16 << code);
    endfunction

    function automatic logic [31:0] ctrl_word(input int p, input int code, input bit run,
                                              input bit ien, input bit ren);
        return (32'(p) << 8) | (32'(code) << 3) | (32'(run) << 5) | (32'(ien) << 2) | 32'(ren);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_w(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_r(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, v2;
        int p0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_r(4'h0, v); chk("R1 ctrl", v, 32'h8019);
        bus_r(4'h4, v); chk("R1 reload", v, 32'h8000);
        bus_r(4'h8, v); chk("R1 counter", v, 32'h8000);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 sys_rst", {31'b0, sys_rst}, 32'h0);

        // R2 readback masks
        bus_w(4'h0, 32'hFFFF_FF1E);
        bus_r(4'h0, v); chk("R2 ctrl fields", v, 32'h0000_FF1C);
        bus_w(4'h4, 32'hABCD_1234);
        bus_r(4'h4, v); chk("R2 reload width", v, 32'h0000_1234);
        bus_r(4'hC, v); chk("R2 clear reads zero", v, 32'h0);

        // R3 random tick-rate checks
        for (int i = 0; i < 12; i++) begin
            int p, code, c, n, t;
            p = $urandom % 4; code = $urandom % 4;
            c = 1000 + ($urandom % 1000);
            t = period(p, code);
            n = 1 + ($urandom % (3 * t));
            bus_w(4'h0, ctrl_word(p, code, 0, 0, 0));
            bus_w(4'h8, 32'(c));
            bus_w(4'h0, ctrl_word(p, code, 1, 0, 0));
            wait_n(n);
            bus_r(4'h8, v);
            chk("R3 decrement rate", v, 32'(c - n / t));
        end

        // R9 stop holds counter
        bus_w(4'h0, ctrl_word(0, 0, 0, 0, 0));
        bus_r(4'h8, v);
        wait_n(100);
        bus_r(4'h8, v2); chk("R9 hold while stopped", v2, v);

        // R4 R5 R6 expiry with both actions
        bus_w(4'h4, 32'h55);
        bus_w(4'h8, 32'h1);
        p0 = pulses;
        bus_w(4'h0, ctrl_word(0, 0, 1, 1, 1));
        wait_n(31);
        bus_r(4'h8, v); chk("R4 counter at zero before expiry", v, 32'h0);
        chk("R6 no pulse before expiry", {31'b0, sys_rst}, 32'h0);
        wait_n(1);
        bus_r(4'h8, v); chk("R4 reload on expiry", v, 32'h55);
        chk("R6 pulse after expiry", {31'b0, sys_rst}, 32'h1);
        chk("R5 irq on expiry", {31'b0, irq}, 32'h1);
        wait_n(1);
        chk("R6 pulse one clock", {31'b0, sys_rst}, 32'h0);
        chk("R6 pulse count", 32'(pulses - p0), 32'h1);
        chk("R5 irq level held", {31'b0, irq}, 32'h1);

        // R8 clear semantics
        bus_w(4'hC, 32'h0);
        chk("R8 clear with bit0=0 ignored", {31'b0, irq}, 32'h1);
        bus_w(4'hC, 32'h1);
        chk("R8 clear", {31'b0, irq}, 32'h0);

        // R7 keepalive while running
        bus_w(4'h8, 32'h300);
        bus_r(4'h8, v); chk("R7 keepalive load", v, 32'h300);

        // R5 R6 expiry with neither action
        bus_w(4'h0, ctrl_word(0, 0, 0, 0, 0));
        bus_w(4'h8, 32'h0);
        p0 = pulses;
        bus_w(4'h0, ctrl_word(0, 0, 1, 0, 0));
        wait_n(16);
        bus_r(4'h8, v); chk("R4 reload, actions off", v, 32'h55);
        wait_n(4);
        chk("R5 irq masked", {31'b0, irq}, 32'h0);
        chk("R6 no pulse when disabled", 32'(pulses - p0), 32'h0);

        // R5 irq only
        bus_w(4'h0, ctrl_word(0, 0, 0, 0, 0));
        bus_w(4'h8, 32'h0);
        p0 = pulses;
        bus_w(4'h0, ctrl_word(0, 0, 1, 1, 0));
        wait_n(16);
        chk("R5 irq without reset", {31'b0, irq}, 32'h1);
        chk("R6 no pulse, irq only", 32'(pulses - p0), 32'h0);
        bus_w(4'hC, 32'h1);

        // R8 clear and expiry in the same cycle
        bus_w(4'h0, ctrl_word(0, 0, 0, 0, 0));
        bus_w(4'h8, 32'h0);
        bus_w(4'h0, ctrl_word(0, 0, 1, 1, 0));
        wait_n(15);
        bus_w(4'hC, 32'h1);
        bus_r(4'h8, v); chk("R4 expiry at clear edge", v, 32'h55);
        chk("R8 clear wins over expiry", {31'b0, irq}, 32'h0);
        wait_n(16 * 32'h56);
        chk("R5 next expiry raises irq", {31'b0, irq}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule